// File: doc/BRIEF.md
# Configurable Symmetric Pre-Adder

This block is the arithmetic stage that sits ahead of the coefficient multipliers in a linear-phase FIR filter. Each tap lane receives one sample from the forward delay line and one from the reverse delay line. It combines the two into a single value, so one multiplier serves a pair of taps that share a coefficient. The block has a parameterised number of such lanes, and all of them share one small configuration register.

The register picks the operation: either the sum, or the reverse sample minus the forward sample. The subtraction suits antisymmetric filters. Two further bits decide, each on its own, whether an operand comes from its delay line or is forced to zero. With these a lane can pass through a single path or be cleared.

Each lane's result is registered and is one bit wider than its inputs, so no input combination can overflow it. In an odd-length filter the centre sample reaches both operands of the last lane. Software must therefore program half of the centre coefficient. The pre-adder itself does not compensate for this.

Top module: `symmetric_preadd`

## Requirements
- R1: When `rst` is high at a clock edge, every lane result becomes 0 and the configuration becomes all-zero. The all-zero configuration means sum mode with both operands forced to zero.
- R2: With configuration bit 0 = 0 and bits 1 and 2 both = 1, each lane's result is fwd + rev, taken as two's complement and sign-extended to DATA_W+1 bits.
- R3: With configuration bit 0 = 1 and bits 1 and 2 both = 1, each lane's result is rev − fwd. The operands are not swapped.
- R4: Configuration bit 1 = 0 forces the forward operand to zero in every lane. The lane result then behaves as if fwd were 0.
- R5: Configuration bit 2 = 0 forces the reverse operand to zero in every lane. The lane result then behaves as if rev were 0.
- R6: Bits 11 to 3 of `cfg_wdata` have no effect on any result.
- R7: A configuration written with `cfg_we` at edge k governs the data sampled at edge k+1 and later. Data sampled at edge k still uses the old configuration. Without `cfg_we`, the configuration holds.
- R8: A lane result appears one clock edge after its inputs are sampled, and each lane depends only on its own two inputs.
- R9: The extreme values are exact with no wrap: −512 + −512 = −1024, 511 − (−512) = 1023, and −512 − 511 = −1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 12 | Configuration word: bit 0 operation, bit 1 forward enable, bit 2 reverse enable, rest reserved |
| fwd_data | input | NUM_TAPS*DATA_W | Forward-path samples, lane i at bits [i*DATA_W +: DATA_W] |
| rev_data | input | NUM_TAPS*DATA_W | Reverse-path samples, packed the same way |
| sum_out | output | NUM_TAPS*(DATA_W+1) | Registered lane results, lane i at bits [i*(DATA_W+1) +: DATA_W+1] |

## Verification
Lane results are due one edge after their samples are taken. A configuration write lands one edge before the first data it governs. The bench drives every input on the falling edge and reads `sum_out` on the next falling edge, which is exactly one rising edge later. The timing test places a configuration write and a data vector in the same cycle. It then expects the old configuration on that vector and the new one on the vector that follows.

// File: rtl/spa_pkg.sv
package spa_pkg;
  localparam int CFG_W      = 12;
  localparam int BIT_OP     = 0;
  localparam int BIT_KEEP_F = 1;
  localparam int BIT_KEEP_R = 2;
  localparam int LIVE_BITS  = 3;

  typedef struct packed {
    logic keep_rev;
    logic keep_fwd;
    logic rev_minus_fwd;
  } spa_cfg_t;

  function automatic spa_cfg_t spa_decode(input logic [LIVE_BITS-1:0] w);
    spa_cfg_t c;
    c.rev_minus_fwd = w[BIT_OP];
    c.keep_fwd      = w[BIT_KEEP_F];
    c.keep_rev      = w[BIT_KEEP_R];
    return c;
  endfunction
endpackage

// File: rtl/spa_cfg_reg.sv
module spa_cfg_reg
  import spa_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output spa_cfg_t         cfg
);
  // reserved field folded into a deliberately unused net
  logic reserved_unused;
  assign reserved_unused = ^wdata[CFG_W-1:LIVE_BITS];

  always_ff @(posedge clk) begin
    if (rst)     cfg <= '0;
    else if (we) cfg <= spa_decode(wdata[LIVE_BITS-1:0]);
  end

  assert_cfg_reset_R1: assert property (@(posedge clk) rst |=> cfg == '0);
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg));
  assert_cfg_load_R6: assert property (@(posedge clk) disable iff (rst)
    we |=> cfg == spa_decode($past(wdata[LIVE_BITS-1:0])));
endmodule

// File: rtl/spa_gate.sv
module spa_gate #(
  parameter int IN_W  = 10,
  parameter int OUT_W = IN_W + 1
) (
  input  logic                    pass,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  always_comb begin
    dout = pass ? OUT_W'(din) : '0;
  end
endmodule

// File: rtl/spa_lane.sv
module spa_lane
  import spa_pkg::*;
#(
  parameter int DATA_W = 10,
  localparam int RES_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  spa_cfg_t                 cfg,
  input  logic signed [DATA_W-1:0] fwd,
  input  logic signed [DATA_W-1:0] rev,
  output logic signed [RES_W-1:0]  res
);
  logic signed [RES_W-1:0] op_a, op_b, nxt;

  spa_gate #(.IN_W(DATA_W), .OUT_W(RES_W)) u_gate_a (
    .pass(cfg.keep_fwd), .din(fwd), .dout(op_a));
  spa_gate #(.IN_W(DATA_W), .OUT_W(RES_W)) u_gate_b (
    .pass(cfg.keep_rev), .din(rev), .dout(op_b));

  always_comb begin
    if (cfg.rev_minus_fwd) nxt = op_b - op_a;
    else                   nxt = op_a + op_b;
  end

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else     res <= nxt;
  end

  assert_lane_reset_R1: assert property (@(posedge clk) rst |=> res == '0);
  assert_both_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg.keep_fwd && !cfg.keep_rev) |=> res == '0);
  assert_rev_only_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg.keep_fwd && cfg.keep_rev) |=> res == RES_W'($past(rev)));
  assert_neg_fwd_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg.keep_fwd && !cfg.keep_rev && cfg.rev_minus_fwd)
      |=> res == -RES_W'($past(fwd)));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg.keep_fwd && cfg.keep_rev && !cfg.rev_minus_fwd)
      |=> (res[RES_W-1] == 1'b0) || ($past(fwd[DATA_W-1]) || $past(rev[DATA_W-1])));
endmodule

// File: rtl/symmetric_preadd.sv
module symmetric_preadd
  import spa_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int NUM_TAPS = 4,
  localparam int RES_W   = DATA_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic [NUM_TAPS*DATA_W-1:0] fwd_data,
  input  logic [NUM_TAPS*DATA_W-1:0] rev_data,
  output logic [NUM_TAPS*RES_W-1:0]  sum_out
);
  spa_cfg_t cfg;

  spa_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg));

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_lane
    logic signed [RES_W-1:0] lane_res;
    spa_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk),
      .rst(rst),
      .cfg(cfg),
      .fwd(fwd_data[i*DATA_W +: DATA_W]),
      .rev(rev_data[i*DATA_W +: DATA_W]),
      .res(lane_res)
    );
    assign sum_out[i*RES_W +: RES_W] = lane_res;
  end
endmodule

// File: tb/symmetric_preadd_tb_top.sv
module symmetric_preadd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 10;
  localparam int N  = 4;
  localparam int OW = W + 1;

  logic clk = 1'b0;
  logic rst, cfg_we;
  logic [11:0] cfg_wdata;
  logic [N*W-1:0] fwd_data, rev_data;
  logic [N*OW-1:0] sum_out;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  symmetric_preadd #(.DATA_W(W), .NUM_TAPS(N)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fwd_data(fwd_data), .rev_data(rev_data), .sum_out(sum_out));

  function automatic int model(input int a, input int b, input logic [2:0] c);
    int a2 = c[1] ? a : 0;
    int b2 = c[2] ? b : 0;
    return c[0] ? (b2 - a2) : (a2 + b2);
  endfunction

  task automatic drive(input int fa[N], input int rb[N]);
    for (int i = 0; i < N; i++) begin
      fwd_data[i*W +: W] = fa[i][W-1:0];
      rev_data[i*W +: W] = rb[i][W-1:0];
    end
  endtask

  task automatic check(input string req, input int fa[N], input int rb[N],
                       input logic [2:0] c);
    for (int i = 0; i < N; i++) begin
      int got = int'($signed(sum_out[i*OW +: OW]));
      int exp = model(fa[i], rb[i], c);
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s lane %0d: got %0d expected %0d", req, i, got, exp);
      end
    end
  endtask

  // called at a falling edge; ends at a falling edge
  task automatic write_cfg(input logic [11:0] w);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input string req, input int fa[N], input int rb[N],
                         input logic [2:0] c);
    drive(fa, rb);
    @(negedge clk);
    check(req, fa, rb, c);
  endtask

  task automatic t_reset();
    int z[N] = '{0, 0, 0, 0};
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
    fwd_data = '1; rev_data = '1;
    repeat (2) @(negedge clk);
    check("R1 reset out", z, z, 3'b000);
    rst = 1'b0;
    // config after reset is all-zero: both operands gated
    run_vec("R1 reset cfg", '{5, -7, 100, 3}, '{9, 2, -50, 1}, 3'b000);
  endtask

  task automatic t_sum();
    write_cfg(12'h006);
    run_vec("R2 sum a", '{1, -2, 300, -100}, '{2, -3, 200, 50}, 3'b110);
    run_vec("R2 sum b", '{0, 17, -256, 511}, '{-1, -17, -256, 0}, 3'b110);
  endtask

  task automatic t_diff();
    write_cfg(12'h007);
    run_vec("R3 diff a", '{10, -5, 0, 100}, '{3, 5, 7, -100}, 3'b111);
    run_vec("R3 diff b", '{-1, 200, 33, -33}, '{1, 100, 33, 33}, 3'b111);
  endtask

  task automatic t_gate_a();
    write_cfg(12'h004);
    run_vec("R4 fwd gated sum", '{99, -99, 5, 6}, '{1, 2, 3, 4}, 3'b100);
    write_cfg(12'h005);
    run_vec("R4 fwd gated diff", '{99, -99, 5, 6}, '{-1, -2, 3, 4}, 3'b101);
  endtask

  task automatic t_gate_b();
    write_cfg(12'h002);
    run_vec("R5 rev gated sum", '{7, -8, 9, -10}, '{100, 200, -300, 400}, 3'b010);
    write_cfg(12'h003);
    run_vec("R5 rev gated diff", '{7, -8, 9, -10}, '{100, 200, -300, 400}, 3'b011);
  endtask

  task automatic t_reserved();
    write_cfg(12'hFF8 | 12'h006);
    run_vec("R6 reserved set sum", '{4, 5, -6, 7}, '{1, 1, 1, 1}, 3'b110);
    write_cfg(12'hAA8);
    run_vec("R6 reserved only", '{4, 5, -6, 7}, '{1, 1, 1, 1}, 3'b000);
  endtask

  task automatic t_timing();
    int fa1[N] = '{11, 22, 33, 44};
    int rb1[N] = '{1, 2, 3, 4};
    int fa2[N] = '{50, -60, 70, -80};
    int rb2[N] = '{5, 6, 7, 8};
    write_cfg(12'h006);
    // write and data in the same cycle: data still sees the old config
    cfg_we = 1'b1; cfg_wdata = 12'h007; drive(fa1, rb1);
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 12'h000;
    check("R7 old cfg on write cycle", fa1, rb1, 3'b110);
    run_vec("R7 new cfg next cycle", fa2, rb2, 3'b111);
    // strobe low with garbage wdata: config holds
    cfg_wdata = 12'h001;
    run_vec("R7 hold without strobe", fa1, rb2, 3'b111);
  endtask

  task automatic t_latency();
    int fa[N] = '{1, 2, 3, 4};
    int rb[N] = '{10, 20, 30, 40};
    write_cfg(12'h006);
    drive(fa, rb);
    #1;
    total++;
    if (sum_out[OW-1:0] === 11'(11)) begin
      bad++;
      $display("FAIL R8 lane 0 early: got %0d expected not %0d",
               int'($signed(sum_out[OW-1:0])), 11);
    end
    @(negedge clk);
    check("R8 one edge latency", fa, rb, 3'b110);
    run_vec("R8 lane independence", '{0, 0, 0, 100}, '{0, 0, 0, 0}, 3'b110);
  endtask

  task automatic t_extremes();
    write_cfg(12'h006);
    run_vec("R9 sum extremes", '{-512, 511, -512, 511}, '{-512, 511, 511, -1}, 3'b110);
    write_cfg(12'h007);
    run_vec("R9 diff extremes", '{-512, 511, 511, -512}, '{511, -512, 511, -512}, 3'b111);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sum();
    t_diff();
    t_gate_a();
    t_gate_b();
    t_reserved();
    t_timing();
    t_latency();
    t_extremes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule